// File: doc/BRIEF.md
# Two-Wire Paged Memory Slave

This block is a slave on a two-wire serial bus in front of a small byte-wide storage array. It watches the synchronised clock and data lines for START and STOP, compares the first byte of each transfer against a fixed device identifier and two strap inputs, and takes a two-byte word address. Write transfers fill a one-page staging buffer. Read transfers stream bytes from the array.

A write that ends in a valid STOP starts a self-timed busy period. During that period the staged page is copied into the array and the slave refuses its own address, so a master can poll for completion by sending address bytes until one is acknowledged. Neighbouring logic supplies a global write-allow level, a protection limit below which data bytes are refused, and an abort pulse that drops the current transfer at once. The slave only pulls the data line low: its single data output is an active-high pull-down enable for an open-drain pad.

Top module: `twm_slave`

## Requirements
- R1: The first byte after a START is read as bits 7..4 = 1010, bit 3 = 0, bits 2..1 = the two select inputs (bit 2 = sel_i[1]), and bit 0 = direction (1 = read). The slave acknowledges this byte only when every one of these fields matches and it is not busy. On any mismatch it stays silent until the next START.
- R2: After a write-direction address byte, the next two bytes form the word address, high byte first. Only the low MEM_AW bits are kept, and each of these bytes is acknowledged.
- R3: Each accepted data byte is acknowledged. After each data byte, accepted or not, the low PAGE_AW address bits advance by one and wrap inside the same page, while the page bits never change. A later byte to the same location replaces the earlier one.
- R4: The array changes only through a STOP that follows at least one accepted data byte and its acknowledge slot. A STOP that arrives inside a data byte, or one that follows no accepted byte, leaves the array unchanged and starts no busy period. Array writes happen only while busy.
- R5: A committing STOP starts a busy period of BUSY_CYCLES clock cycles. While it lasts, the address byte is not acknowledged. When it ends, the written data can be read back.
- R6: A read returns the byte at the address counter and then advances the counter across the whole array, rolling from the last location to 0. The slave keeps sending while the master acknowledges and stops driving after a master NACK.
- R7: A repeated START after the word address turns the transfer into a read from that address. A STOP right after the word address only loads the counter, so a later read with no address continues from it.
- R8: A data byte is refused (NACK) and not stored when wr_allow_i is low or when its address is below prot_top_i. The address counter still advances.
- R9: A START is a falling data line while the clock is high, and a STOP is a rising data line while the clock is high. With no START, bus activity is ignored. The pull-down enable changes only after a clock fall.
- R10: An abort pulse returns the slave to idle, releases the data line in the next cycle and discards the staged bytes without a write.
- R11: While reset is held and just after it is released, the data line is released and the slave is idle, ready to acknowledge its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level (asynchronous) |
| sda_i | input | 1 | Bus data line level (asynchronous) |
| sda_oe_o | output | 1 | Pull the data line low when 1 |
| sel_i | input | 2 | Device select straps compared with address bits 2..1 |
| wr_allow_i | input | 1 | Global write permission for data bytes |
| prot_top_i | input | MEM_AW | Addresses below this value are write-protected |
| abort_i | input | 1 | Drop the current transfer and return to idle |

## Verification
On every cycle the assertions check four things: the address byte is refused during the busy period, refused data bytes are never acknowledged, an abort releases the line on the next cycle, and the pull-down enable only rises after a bus clock fall. They also check that the page bits of the write address hold through a write and that the array is written only inside the busy period. The scenarios cover what needs a whole transfer to show: the in-page wrap and overwrite of a 70-byte write, the rollover of a read that crosses the end of the array, and a STOP placed inside a byte. They also show acknowledge polling ending once the busy period has passed, and the set-current-address form. A full fill and readback of the array checks every location.

// File: rtl/twm_pkg.sv
package twm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WDAT,
        ST_RDAT,
        ST_SKIP
    } twm_state_e;

    localparam logic [3:0] TWM_DEV_ID = 4'b1010;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda_lvl;
    } twm_bus_ev_t;

    function automatic logic twm_addr_hit(input logic [7:0] b, input logic [1:0] sel);
        return (b[7:4] == TWM_DEV_ID) && (b[3] == 1'b0) && (b[2:1] == sel);
    endfunction

endpackage

// File: rtl/twm_bus_edges.sv
module twm_bus_edges
    import twm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_i,
    input  logic        sda_i,
    output twm_bus_ev_t ev
);
    logic scl_m, scl_s, scl_d;
    logic sda_m, sda_s, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            {scl_m, scl_s, scl_d} <= 3'b111;
            {sda_m, sda_s, sda_d} <= 3'b111;
        end else begin
            {scl_m, scl_s, scl_d} <= {scl_i, scl_m, scl_s};
            {sda_m, sda_s, sda_d} <= {sda_i, sda_m, sda_s};
        end
    end

    always_comb begin
        ev.scl_rise = scl_s & ~scl_d;
        ev.scl_fall = ~scl_s & scl_d;
        ev.start    = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop     = scl_s & scl_d & ~sda_d & sda_s;
        ev.sda_lvl  = sda_s;
    end
endmodule

// File: rtl/twm_busy_timer.sv
module twm_busy_timer #(
    parameter int BUSY_N  = 1000,
    parameter int PAGE_AW = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    output logic               busy_o,
    output logic               walk_en_o,
    output logic [PAGE_AW-1:0] walk_idx_o
);
    localparam int CW = $clog2(BUSY_N + 1);
    localparam logic [CW-1:0] FULL   = CW'(BUSY_N);
    localparam logic [CW-1:0] PAGE_N = CW'(1 << PAGE_AW);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] elapsed;

    always_ff @(posedge clk) begin
        if (rst)              cnt_q <= '0;
        else if (start_i)     cnt_q <= FULL;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign elapsed    = FULL - cnt_q;
    assign busy_o     = (cnt_q != '0);
    assign walk_en_o  = busy_o && (elapsed < PAGE_N);
    assign walk_idx_o = elapsed[PAGE_AW-1:0];
endmodule

// File: rtl/twm_store.sv
module twm_store #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [7:0]    wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [7:0]    rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/twm_slave.sv
module twm_slave
    import twm_pkg::*;
#(
    parameter int MEM_AW      = 9,
    parameter int PAGE_AW     = 6,
    parameter int BUSY_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [1:0]        sel_i,
    input  logic              wr_allow_i,
    input  logic [MEM_AW-1:0] prot_top_i,
    input  logic              abort_i
);
    localparam int PAGE_N = 1 << PAGE_AW;
    localparam int BUSY_N = (BUSY_CYCLES < PAGE_N) ? PAGE_N : BUSY_CYCLES;

    twm_bus_ev_t        ev;
    twm_state_e         st_q;
    logic [3:0]         bitcnt_q;
    logic [7:0]         shreg_q, txbyte_q;
    logic [MEM_AW-9:0]  ahi_q;
    logic [MEM_AW-1:0]  addr_q;
    logic [PAGE_N-1:0]  pval_q;
    logic [7:0]         pbuf_q [PAGE_N];
    logic               oe_q, mack_q, lead_q, got_q;

    logic               busy, walk_en, mem_we, accept, hit, commit, buf_we;
    logic [PAGE_AW-1:0] walk_idx;
    logic [7:0]         rd_data;

    twm_bus_edges u_edges (.clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev));

    twm_busy_timer #(.BUSY_N(BUSY_N), .PAGE_AW(PAGE_AW)) u_timer (
        .clk(clk), .rst(rst), .start_i(commit),
        .busy_o(busy), .walk_en_o(walk_en), .walk_idx_o(walk_idx)
    );

    twm_store #(.AW(MEM_AW)) u_store (
        .clk(clk), .we_i(mem_we),
        .waddr_i({addr_q[MEM_AW-1:PAGE_AW], walk_idx}),
        .wdata_i(pbuf_q[walk_idx]),
        .raddr_i(addr_q), .rdata_o(rd_data)
    );

    assign accept   = wr_allow_i && (addr_q >= prot_top_i);
    assign hit      = twm_addr_hit(shreg_q, sel_i) && !busy;
    assign mem_we   = walk_en && pval_q[walk_idx];
    assign buf_we   = !rst && !abort_i && (st_q == ST_WDAT) && ev.scl_fall
                      && (bitcnt_q == 4'd8) && accept;
    assign commit   = !rst && !abort_i && ev.stop && (st_q == ST_WDAT)
                      && got_q && (bitcnt_q <= 4'd1);
    assign sda_oe_o = oe_q;

    always_ff @(posedge clk) begin
        if (buf_we) pbuf_q[addr_q[PAGE_AW-1:0]] <= shreg_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            bitcnt_q <= '0;
            shreg_q  <= '0;
            txbyte_q <= '0;
            ahi_q    <= '0;
            addr_q   <= '0;
            pval_q   <= '0;
            oe_q     <= 1'b0;
            mack_q   <= 1'b0;
            lead_q   <= 1'b0;
            got_q    <= 1'b0;
        end else if (abort_i || ev.stop) begin
            st_q     <= ST_IDLE;
            bitcnt_q <= '0;
            oe_q     <= 1'b0;
            lead_q   <= 1'b0;
            got_q    <= 1'b0;
        end else if (ev.start) begin
            st_q     <= ST_DEV;
            bitcnt_q <= '0;
            oe_q     <= 1'b0;
            lead_q   <= 1'b0;
            got_q    <= 1'b0;
        end else if (st_q != ST_IDLE) begin
            if (ev.scl_rise) begin
                if (bitcnt_q < 4'd8) begin
                    shreg_q  <= {shreg_q[6:0], ev.sda_lvl};
                    bitcnt_q <= bitcnt_q + 4'd1;
                end else if (bitcnt_q == 4'd8) begin
                    mack_q   <= ~ev.sda_lvl;
                    bitcnt_q <= 4'd9;
                end
            end else if (ev.scl_fall) begin
                if (bitcnt_q == 4'd8) begin
                    unique case (st_q)
                        ST_DEV: begin
                            if (hit) begin
                                oe_q <= 1'b1;
                                if (shreg_q[0]) begin
                                    st_q     <= ST_RDAT;
                                    lead_q   <= 1'b1;
                                    txbyte_q <= rd_data;
                                    addr_q   <= addr_q + 1'b1;
                                end else begin
                                    st_q <= ST_AHI;
                                end
                            end else begin
                                st_q <= ST_SKIP;
                            end
                        end
                        ST_AHI: begin
                            ahi_q <= shreg_q[MEM_AW-9:0];
                            oe_q  <= 1'b1;
                            st_q  <= ST_ALO;
                        end
                        ST_ALO: begin
                            addr_q <= {ahi_q, shreg_q};
                            pval_q <= '0;
                            got_q  <= 1'b0;
                            oe_q   <= 1'b1;
                            st_q   <= ST_WDAT;
                        end
                        ST_WDAT: begin
                            oe_q <= accept;
                            if (accept) begin
                                pval_q[addr_q[PAGE_AW-1:0]] <= 1'b1;
                                got_q <= 1'b1;
                            end
                            addr_q <= {addr_q[MEM_AW-1:PAGE_AW], addr_q[PAGE_AW-1:0] + 1'b1};
                        end
                        default: oe_q <= 1'b0;
                    endcase
                end else if (bitcnt_q == 4'd9) begin
                    bitcnt_q <= '0;
                    oe_q     <= 1'b0;
                    if (st_q == ST_RDAT) begin
                        if (lead_q) begin
                            oe_q   <= ~txbyte_q[7];
                            lead_q <= 1'b0;
                        end else if (mack_q) begin
                            txbyte_q <= rd_data;
                            addr_q   <= addr_q + 1'b1;
                            oe_q     <= ~rd_data[7];
                        end else begin
                            st_q <= ST_SKIP;
                        end
                    end
                end else if ((st_q == ST_RDAT) && (bitcnt_q != 4'd0)) begin
                    oe_q <= ~txbyte_q[3'd7 - bitcnt_q[2:0]];
                end
            end
        end
    end
endmodule

// File: rtl/twm_slave_chk.sv
module twm_slave_chk
    import twm_pkg::*;
#(
    parameter int MEM_AW  = 9,
    parameter int PAGE_AW = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              abort_i,
    input logic              sda_oe,
    input twm_bus_ev_t       ev,
    input twm_state_e        st,
    input logic [3:0]        bitcnt,
    input logic              busy,
    input logic              mem_we,
    input logic              accept,
    input logic [MEM_AW-1:0] addr
);
    AST_BUSY_ADDR_NACK: assert property (@(posedge clk) disable iff (rst)
        (ev.scl_fall && bitcnt == 4'd8 && st == ST_DEV && busy) |=> !sda_oe); // R5

    AST_LOCKED_DATA_NACK: assert property (@(posedge clk) disable iff (rst)
        (ev.scl_fall && bitcnt == 4'd8 && st == ST_WDAT && !accept) |=> !sda_oe); // R8

    AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        abort_i |=> !sda_oe); // R10

    AST_PULL_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> $past(ev.scl_fall)); // R9

    AST_ARRAY_WRITE_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy); // R4

    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ev.scl_fall && bitcnt == 4'd8 && st == ST_WDAT)
        |=> (addr[MEM_AW-1:PAGE_AW] == $past(addr[MEM_AW-1:PAGE_AW]))); // R3
endmodule

bind twm_slave twm_slave_chk #(.MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW)) u_chk (
    .clk(clk), .rst(rst), .abort_i(abort_i), .sda_oe(sda_oe_o), .ev(ev),
    .st(st_q), .bitcnt(bitcnt_q), .busy(busy), .mem_we(mem_we),
    .accept(accept), .addr(addr_q)
);

// File: tb/test_twm_slave.sv
module test_twm_slave;
    localparam int AW   = 9;
    localparam int SIZE = 1 << AW;
    localparam int BUSY = 1000;

    logic          clk = 1'b0;
    logic          rst, scl_m, sda_m, wr_allow, abort;
    logic [1:0]    sel;
    logic [AW-1:0] prot_top;
    logic          sda_oe;
    logic          sda_line;
    logic [7:0]    model [SIZE];
    int            n_chk = 0;
    int            n_err = 0;

    always #4 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    twm_slave #(.MEM_AW(AW), .PAGE_AW(6), .BUSY_CYCLES(BUSY)) i_twm_slave (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .sel_i(sel), .wr_allow_i(wr_allow), .prot_top_i(prot_top), .abort_i(abort)
    );

    task automatic w(input int n); repeat (n) @(negedge clk); endtask

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bit_out(input logic b);
        w(3); sda_m = b; w(3); scl_m = 1'b1; w(6); scl_m = 1'b0;
    endtask

    task automatic bit_in(output logic b);
        w(3); sda_m = 1'b1; w(3); scl_m = 1'b1; w(3); b = sda_line; w(3); scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) bit_out(d[i]);
        bit_in(b);
        ack = !b;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) bit_in(d[i]);
        bit_out(!mack);
    endtask

    task automatic bus_start;
        w(3); sda_m = 1'b1; w(3); scl_m = 1'b1; w(6); sda_m = 1'b0; w(6); scl_m = 1'b0;
    endtask

    task automatic bus_stop;
        w(3); sda_m = 1'b0; w(3); scl_m = 1'b1; w(6); sda_m = 1'b1; w(6);
    endtask

    function automatic logic [7:0] dev(input logic rd);
        return {4'b1010, 1'b0, sel, rd};
    endfunction

    task automatic send_addr(input int a, input string req);
        logic ack;
        send_byte(dev(1'b0), ack); chk(ack, req, ack, 1);
        send_byte(8'((a >> 8) & 8'hFF), ack); chk(ack, "R2", ack, 1);
        send_byte(8'(a & 8'hFF), ack); chk(ack, "R2", ack, 1);
    endtask

    // page write; model is updated only when at least one byte was accepted
    task automatic page_write(input int a, input int n, input int seed, input bit wait_busy);
        int pa[128];
        logic [7:0] pd[128];
        int np = 0;
        logic ack, exp;
        bus_start;
        send_addr(a, "R1");
        for (int i = 0; i < n; i++) begin
            int aa = (a & (SIZE - 64)) | ((a + i) & 63);
            logic [7:0] d = 8'((aa * seed + i) & 255);
            exp = wr_allow && (aa >= int'(prot_top));
            send_byte(d, ack);
            chk(ack == exp, exp ? "R3" : "R8", ack, exp);
            if (exp) begin pa[np] = aa; pd[np] = d; np++; end
        end
        bus_stop;
        for (int k = 0; k < np; k++) model[pa[k]] = pd[k];
        if (wait_busy) w(BUSY + 60);
    endtask

    task automatic read_check(input int a, input int n, input string req);
        logic ack;
        logic [7:0] d;
        bus_start;
        send_addr(a, "R1");
        bus_start;
        send_byte(dev(1'b1), ack); chk(ack, "R7", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, d);
            chk(d == model[(a + i) % SIZE], req, d, model[(a + i) % SIZE]);
        end
        bus_stop;
    endtask

    task automatic poll(input logic exp, input string req);
        logic ack;
        bus_start;
        send_byte(dev(1'b0), ack);
        chk(ack == exp, req, ack, exp);
        bus_stop;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] d;
        rst = 1'b1; scl_m = 1'b1; sda_m = 1'b1; wr_allow = 1'b1; abort = 1'b0;
        sel = 2'b10; prot_top = '0;
        w(5);
        chk(sda_oe == 1'b0, "R11", sda_oe, 0);
        rst = 1'b0;
        w(5);
        chk(sda_oe == 1'b0, "R11", sda_oe, 0);
        poll(1'b1, "R11");

        // R9: address-like traffic with no START is ignored
        send_byte(dev(1'b0), ack); chk(!ack, "R9", ack, 0);
        bus_stop;

        // R1: select and identifier mismatches
        sel = 2'b10;
        bus_start; send_byte({4'b1010, 1'b0, 2'b01, 1'b0}, ack); chk(!ack, "R1", ack, 0); bus_stop;
        bus_start; send_byte(8'hB4, ack); chk(!ack, "R1", ack, 0); bus_stop;
        bus_start; send_byte(8'hAC, ack); chk(!ack, "R1", ack, 0); bus_stop;

        // fill the whole array page by page, then read it all with rollover
        for (int p = 0; p < SIZE / 64; p++) page_write(p * 64, 64, 37, 1'b1);
        read_check(0, SIZE + 4, "R6");

        // R3: 70 bytes from offset 60 of page 2 wrap and overwrite
        page_write(32'h0BC, 70, 11, 1'b0);
        poll(1'b0, "R5");
        w(BUSY + 60);
        poll(1'b1, "R5");
        read_check(32'h080, 64, "R3");

        // R4: STOP inside a data byte cancels the write and starts no busy period
        bus_start; send_addr(32'h123, "R1");
        for (int i = 0; i < 4; i++) bit_out(1'b1);
        bus_stop;
        poll(1'b1, "R4");
        read_check(32'h120, 8, "R4");

        // R7: set current address, then a read with no address
        bus_start; send_addr(32'h1F0, "R1"); bus_stop;
        bus_start; send_byte(dev(1'b1), ack); chk(ack, "R7", ack, 1);
        recv_byte(1'b1, d); chk(d == model[32'h1F0], "R7", d, model[32'h1F0]);
        recv_byte(1'b0, d); chk(d == model[32'h1F1], "R6", d, model[32'h1F1]);
        bus_stop;

        // R8: write permission removed
        wr_allow = 1'b0;
        page_write(32'h030, 3, 5, 1'b0);
        poll(1'b1, "R8");
        wr_allow = 1'b1;
        read_check(32'h030, 3, "R8");

        // R8: protection limit inside page 1 (0x7E,0x7F accepted, 0x40,0x41 refused)
        prot_top = 9'h042;
        page_write(32'h07E, 4, 3, 1'b1);
        prot_top = '0;
        read_check(32'h07C, 8, "R8");

        // R10: abort during the acknowledge slot of the second data byte
        bus_start; send_addr(32'h150, "R1");
        send_byte(8'h5A, ack); chk(ack, "R3", ack, 1);
        for (int i = 7; i >= 0; i--) bit_out(1'b0);
        w(3); sda_m = 1'b1; w(3); scl_m = 1'b1; w(2);
        abort = 1'b1; w(1); abort = 1'b0; w(1);
        chk(sda_oe == 1'b0, "R10", sda_oe, 0);
        w(2); scl_m = 1'b0;
        bus_stop;
        poll(1'b1, "R10");
        read_check(32'h150, 2, "R10");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule